// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the architectural bookkeeping a processor core needs when it takes a trap. The core raises a one-cycle entry strobe and presents, on the same cycle, the trap type, the delivery mode and the current values of its control state. These are the trap level, global register level, condition codes, address-space identifier, processor state, hyper-state, window pointer, free-window count and the two program counters. On the next clock edge the unit holds the updated trap level, global level, processor state, hyper-state and window pointer. It has also stored the pre-trap context into the save slot addressed by the new trap level.

Delivery mode is decided outside the block and arrives on two flags. The RED-entry flag overrides the hyperprivileged flag. With neither flag set, the trap is delivered at privileged level. Save slots are held in a small memory indexed by trap level. A registered read port returns any slot one cycle after its level is presented, and a read and a write in the same cycle return the slot's earlier contents. The global level width must not exceed 3 bits and the window pointer width must not exceed 5 bits.

Top module: `trap_entry_unit`

## Requirements
- R1: On a strobe, `new_tl` becomes `cur_tl`+1, saturating at MAX_TL (default 6). All save-slot writes for that strobe go to that new level.
- R2: The saved context word has these fields: window pointer in bits 4:0, processor state in bits 20:8, address-space id in bits 31:24, condition codes in bits 39:32 and global level in bits 42:40. All other bits are zero. Every field holds its pre-trap value. Reading level 0 or any level above MAX_TL returns all zeros.
- R3: The same slot stores `cur_pc`, `cur_npc`, the unmodified `cur_hpstate` and the trap type. Each reads back one cycle after `rd_level` selects the slot, and the read returns the old contents when it coincides with a write to that slot.
- R4: `new_gl` is min(`cur_gl`+1, MAX_PGL=2) for privileged delivery, and min(`cur_gl`+1, MAX_GL=3) otherwise.
- R5: On every entry, processor-state bit 4 is set, and bits 3 and 1 are cleared.
- R6: Processor-state bit 2 is set for privileged delivery and cleared otherwise. Bit 9 is cleared only for RED entry. All other processor-state bits are carried through unchanged.
- R7: For RED entry, hyper-state bits 5 and 2 are set and bits 10 and 0 are cleared. RED entry takes precedence when `to_hyper` is also set.
- R8: For hyperprivileged (non-RED) delivery, hyper-state bit 5 is cleared and bit 2 is set. For privileged delivery, the hyper-state passes through unchanged.
- R9: The window pointer moves according to the trap type. Type 0x024 adds 1. Types 0x080 to 0x0BF add `cur_cansave`+2. Types 0x0C0 to 0x0FF subtract 1. Any other type leaves it unchanged.
- R10: The window pointer result wraps modulo NWIN (default 8) in both directions.
- R11: Synchronous active-high reset clears every output. `done` pulses for exactly the cycle after each strobe. Without a strobe, the updated state outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_go | input | 1 | Trap entry strobe |
| trap_kind | input | TTW (9) | Trap type |
| to_hyper | input | 1 | Deliver at hyperprivileged level |
| to_red | input | 1 | RED-state entry (overrides to_hyper) |
| cur_tl | input | TLW (3) | Current trap level |
| cur_gl | input | GLW (2) | Current global level |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space id |
| cur_pstate | input | 13 | Current processor state |
| cur_hpstate | input | 11 | Current hyper-state |
| cur_cwp | input | CWPW (3) | Current window pointer |
| cur_cansave | input | CWPW (3) | Current free-window count |
| cur_pc | input | VAW (64) | Program counter |
| cur_npc | input | VAW (64) | Next program counter |
| rd_level | input | TLW (3) | Save slot to read |
| done | output | 1 | Entry completed pulse |
| new_tl | output | TLW (3) | Updated trap level |
| new_gl | output | GLW (2) | Updated global level |
| new_pstate | output | 13 | Updated processor state |
| new_hpstate | output | 11 | Updated hyper-state |
| new_cwp | output | CWPW (3) | Updated window pointer |
| rd_ctx | output | 43 | Saved context word of the read slot |
| rd_pc | output | VAW (64) | Saved program counter |
| rd_npc | output | VAW (64) | Saved next program counter |
| rd_hpstate | output | 11 | Saved hyper-state |
| rd_kind | output | TTW (9) | Saved trap type |

## Verification
A wrong mode decode or window adjustment appears on the updated state outputs on the first edge after the strobe, so a per-clock comparison catches it at once. A save written to the wrong slot, or a field placed in the wrong bits of the context word, stays hidden until that level is read. For this reason the reference model tracks every slot, and each entry is followed by a read of the level just written, which exposes the fault within two cycles. Occasional reads of the out-of-range levels and of slots written earlier catch stray writes that land on neighbouring levels.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int PS_W   = 13;
  localparam int HPS_W  = 11;
  localparam int CCR_W  = 8;
  localparam int ASI_W  = 8;
  localparam int CTX_W  = 43;

  // context word field positions (a restore path decodes these)
  localparam int CTX_CWP_LSB = 0;
  localparam int CTX_CWP_W   = 5;
  localparam int CTX_PS_LSB  = 8;
  localparam int CTX_ASI_LSB = 24;
  localparam int CTX_CCR_LSB = 32;
  localparam int CTX_GL_LSB  = 40;
  localparam int CTX_GL_W    = 3;

  // processor-state bits
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_CLE  = 9;

  // hyper-state bits
  localparam int HP_TLZ   = 0;
  localparam int HP_HPRIV = 2;
  localparam int HP_RED   = 5;
  localparam int HP_IBE   = 10;

  // trap type classes that move the window pointer
  localparam int TK_CLEAN    = 'h024;
  localparam int TK_SPILL_LO = 'h080;
  localparam int TK_SPILL_HI = 'h0BF;
  localparam int TK_FILL_LO  = 'h0C0;
  localparam int TK_FILL_HI  = 'h0FF;

  typedef enum logic [1:0] {DLV_PRIV, DLV_HYP, DLV_RED} deliver_e;
  typedef enum logic [1:0] {WIN_KEEP, WIN_INC, WIN_SPILL, WIN_DEC} win_act_e;
endpackage

// File: rtl/te_ctx_pack.sv
module te_ctx_pack
  import trap_entry_pkg::*;
#(
  parameter int GLW  = 2,
  parameter int CWPW = 3
) (
  input  logic [GLW-1:0]   gl_in,
  input  logic [CCR_W-1:0] ccr_in,
  input  logic [ASI_W-1:0] asi_in,
  input  logic [PS_W-1:0]  ps_in,
  input  logic [CWPW-1:0]  cwp_in,
  output logic [CTX_W-1:0] ctx_out
);
  always_comb begin
    ctx_out = '0;
    ctx_out[CTX_GL_LSB  +: CTX_GL_W]  = CTX_GL_W'(gl_in);
    ctx_out[CTX_CCR_LSB +: CCR_W]     = ccr_in;
    ctx_out[CTX_ASI_LSB +: ASI_W]     = asi_in;
    ctx_out[CTX_PS_LSB  +: PS_W]      = ps_in;
    ctx_out[CTX_CWP_LSB +: CTX_CWP_W] = CTX_CWP_W'(cwp_in);
  end
endmodule

// File: rtl/te_mode_update.sv
module te_mode_update
  import trap_entry_pkg::*;
#(
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int GLW     = 2
) (
  input  deliver_e         mode,
  input  logic [GLW-1:0]   gl_in,
  input  logic [PS_W-1:0]  ps_in,
  input  logic [HPS_W-1:0] hps_in,
  output logic [GLW-1:0]   gl_out,
  output logic [PS_W-1:0]  ps_out,
  output logic [HPS_W-1:0] hps_out
);
  localparam int GW = GLW + 1;
  logic [GW-1:0] gl_inc, gl_cap;

  always_comb begin
    gl_inc = {1'b0, gl_in} + GW'(1);
    gl_cap = (mode == DLV_PRIV) ? GW'(MAX_PGL) : GW'(MAX_GL);
    gl_out = (gl_inc > gl_cap) ? gl_cap[GLW-1:0] : gl_inc[GLW-1:0];
  end

  always_comb begin
    ps_out          = ps_in;
    ps_out[PS_PEF]  = 1'b1;
    ps_out[PS_AM]   = 1'b0;
    ps_out[PS_IE]   = 1'b0;
    ps_out[PS_PRIV] = (mode == DLV_PRIV);
    if (mode == DLV_RED) ps_out[PS_CLE] = 1'b0;
  end

  always_comb begin
    hps_out = hps_in;
    case (mode)
      DLV_RED: begin
        hps_out[HP_RED]   = 1'b1;
        hps_out[HP_HPRIV] = 1'b1;
        hps_out[HP_IBE]   = 1'b0;
        hps_out[HP_TLZ]   = 1'b0;
      end
      DLV_HYP: begin
        hps_out[HP_RED]   = 1'b0;
        hps_out[HP_HPRIV] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/te_window_move.sv
module te_window_move
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = 3,
  parameter int TTW  = 9
) (
  input  logic [TTW-1:0]  kind,
  input  logic [CWPW-1:0] cwp_in,
  input  logic [CWPW-1:0] cansave_in,
  output logic [CWPW-1:0] cwp_out
);
  localparam int SW = CWPW + 2;
  win_act_e      act;
  logic [SW-1:0] up_one, spill_sum, down_one;

  always_comb begin
    if (kind == TTW'(TK_CLEAN))
      act = WIN_INC;
    else if (kind >= TTW'(TK_SPILL_LO) && kind <= TTW'(TK_SPILL_HI))
      act = WIN_SPILL;
    else if (kind >= TTW'(TK_FILL_LO) && kind <= TTW'(TK_FILL_HI))
      act = WIN_DEC;
    else
      act = WIN_KEEP;
  end

  always_comb begin
    up_one    = SW'(cwp_in) + SW'(1);
    spill_sum = SW'(cwp_in) + SW'(cansave_in) + SW'(2);
    down_one  = SW'(cwp_in) + SW'(NWIN - 1);
    case (act)
      WIN_INC:   cwp_out = CWPW'(up_one    % SW'(NWIN));
      WIN_SPILL: cwp_out = CWPW'(spill_sum % SW'(NWIN));
      WIN_DEC:   cwp_out = CWPW'(down_one  % SW'(NWIN));
      default:   cwp_out = cwp_in;
    endcase
  end
endmodule

// File: rtl/te_save_bank.sv
module te_save_bank #(
  parameter int DEPTH  = 6,
  parameter int LVW    = 3,
  parameter int WORD_W = 191
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LVW-1:0]    wr_lvl,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LVW-1:0]    rd_lvl,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] slots [0:DEPTH];
  logic              rd_out_of_range;

  assign rd_out_of_range = (rd_lvl == '0) || (rd_lvl > LVW'(DEPTH));

  always_ff @(posedge clk) begin
    if (we) slots[wr_lvl] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_word <= '0;
    else if (rd_out_of_range) rd_word <= '0;
    else                      rd_word <= slots[rd_lvl];
  end

  a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ((rd_lvl == '0) || (rd_lvl > LVW'(DEPTH))) |=> (rd_word == '0));

  a_r1_write_in_range: assert property (@(posedge clk) disable iff (rst)
    we |-> (wr_lvl != '0) && (wr_lvl <= LVW'(DEPTH)));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int TTW     = 9,
  parameter int VAW     = 64,
  localparam int TLW    = $clog2(MAX_TL + 1),
  localparam int GLW    = $clog2(MAX_GL + 1),
  localparam int CWPW   = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_go,
  input  logic [TTW-1:0]   trap_kind,
  input  logic             to_hyper,
  input  logic             to_red,
  input  logic [TLW-1:0]   cur_tl,
  input  logic [GLW-1:0]   cur_gl,
  input  logic [7:0]       cur_ccr,
  input  logic [7:0]       cur_asi,
  input  logic [12:0]      cur_pstate,
  input  logic [10:0]      cur_hpstate,
  input  logic [CWPW-1:0]  cur_cwp,
  input  logic [CWPW-1:0]  cur_cansave,
  input  logic [VAW-1:0]   cur_pc,
  input  logic [VAW-1:0]   cur_npc,
  input  logic [TLW-1:0]   rd_level,
  output logic             done,
  output logic [TLW-1:0]   new_tl,
  output logic [GLW-1:0]   new_gl,
  output logic [12:0]      new_pstate,
  output logic [10:0]      new_hpstate,
  output logic [CWPW-1:0]  new_cwp,
  output logic [42:0]      rd_ctx,
  output logic [VAW-1:0]   rd_pc,
  output logic [VAW-1:0]   rd_npc,
  output logic [10:0]      rd_hpstate,
  output logic [TTW-1:0]   rd_kind
);
  localparam int SLOT_W = CTX_W + 2 * VAW + HPS_W + TTW;

  deliver_e          mode;
  logic [TLW-1:0]    tl_next;
  logic [GLW-1:0]    gl_next;
  logic [PS_W-1:0]   ps_next;
  logic [HPS_W-1:0]  hps_next;
  logic [CWPW-1:0]   cwp_next;
  logic [CTX_W-1:0]  ctx_word;
  logic [SLOT_W-1:0] slot_wr, slot_rd;

  logic              done_q;
  logic [TLW-1:0]    tl_q;
  logic [GLW-1:0]    gl_q;
  logic [PS_W-1:0]   ps_q;
  logic [HPS_W-1:0]  hps_q;
  logic [CWPW-1:0]   cwp_q;

  always_comb begin
    if (to_red)        mode = DLV_RED;
    else if (to_hyper) mode = DLV_HYP;
    else               mode = DLV_PRIV;
  end

  assign tl_next = (cur_tl >= TLW'(MAX_TL)) ? TLW'(MAX_TL) : cur_tl + TLW'(1);

  te_mode_update #(.MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL), .GLW(GLW)) u_mode (
    .mode(mode), .gl_in(cur_gl), .ps_in(cur_pstate), .hps_in(cur_hpstate),
    .gl_out(gl_next), .ps_out(ps_next), .hps_out(hps_next)
  );

  te_window_move #(.NWIN(NWIN), .CWPW(CWPW), .TTW(TTW)) u_win (
    .kind(trap_kind), .cwp_in(cur_cwp), .cansave_in(cur_cansave), .cwp_out(cwp_next)
  );

  te_ctx_pack #(.GLW(GLW), .CWPW(CWPW)) u_pack (
    .gl_in(cur_gl), .ccr_in(cur_ccr), .asi_in(cur_asi), .ps_in(cur_pstate),
    .cwp_in(cur_cwp), .ctx_out(ctx_word)
  );

  assign slot_wr = {trap_kind, cur_hpstate, cur_npc, cur_pc, ctx_word};

  te_save_bank #(.DEPTH(MAX_TL), .LVW(TLW), .WORD_W(SLOT_W)) u_bank (
    .clk(clk), .rst(rst), .we(entry_go), .wr_lvl(tl_next), .wr_word(slot_wr),
    .rd_lvl(rd_level), .rd_word(slot_rd)
  );

  assign {rd_kind, rd_hpstate, rd_npc, rd_pc, rd_ctx} = slot_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      tl_q   <= '0;
      gl_q   <= '0;
      ps_q   <= '0;
      hps_q  <= '0;
      cwp_q  <= '0;
    end else begin
      done_q <= entry_go;
      if (entry_go) begin
        tl_q  <= tl_next;
        gl_q  <= gl_next;
        ps_q  <= ps_next;
        hps_q <= hps_next;
        cwp_q <= cwp_next;
      end
    end
  end

  assign done        = done_q;
  assign new_tl      = tl_q;
  assign new_gl      = gl_q;
  assign new_pstate  = ps_q;
  assign new_hpstate = hps_q;
  assign new_cwp     = cwp_q;

  a_r1_level_step: assert property (@(posedge clk) disable iff (rst)
    (entry_go && (cur_tl < TLW'(MAX_TL))) |=> (tl_q == $past(cur_tl) + TLW'(1)));

  a_r1_level_ceiling: assert property (@(posedge clk) disable iff (rst)
    entry_go |=> (tl_q <= TLW'(MAX_TL)));

  a_r4_priv_gl_cap: assert property (@(posedge clk) disable iff (rst)
    (entry_go && !to_red && !to_hyper) |=> (gl_q <= GLW'(MAX_PGL)));

  a_r5_pstate_forced: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (ps_q[PS_PEF] && !ps_q[PS_AM] && !ps_q[PS_IE]));

  a_r7_red_flags: assert property (@(posedge clk) disable iff (rst)
    (entry_go && to_red) |=> (hps_q[HP_RED] && hps_q[HP_HPRIV] && !hps_q[HP_IBE] && !hps_q[HP_TLZ]));

  a_r8_priv_keeps_hpstate: assert property (@(posedge clk) disable iff (rst)
    (entry_go && !to_red && !to_hyper) |=> (hps_q == $past(cur_hpstate)));

  a_r9_window_untouched: assert property (@(posedge clk) disable iff (rst)
    (entry_go && (trap_kind != TTW'(TK_CLEAN)) &&
     !((trap_kind >= TTW'(TK_SPILL_LO)) && (trap_kind <= TTW'(TK_FILL_HI))))
    |=> (cwp_q == $past(cur_cwp)));

  a_r11_done_after_go: assert property (@(posedge clk) disable iff (rst)
    entry_go |=> done_q);

  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    !entry_go |=> (!done_q && $stable(tl_q) && $stable(gl_q) && $stable(cwp_q)));
endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
  localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 3, MAX_PGL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_go = 1'b0, to_hyper = 1'b0, to_red = 1'b0;
  logic [8:0]  trap_kind = '0;
  logic [2:0]  cur_tl = '0, cur_cwp = '0, cur_cansave = '0, rd_level = '0;
  logic [1:0]  cur_gl = '0;
  logic [7:0]  cur_ccr = '0, cur_asi = '0;
  logic [12:0] cur_pstate = '0;
  logic [10:0] cur_hpstate = '0;
  logic [63:0] cur_pc = '0, cur_npc = '0;
  logic        done;
  logic [2:0]  new_tl, new_cwp;
  logic [1:0]  new_gl;
  logic [12:0] new_pstate;
  logic [10:0] new_hpstate, rd_hpstate;
  logic [42:0] rd_ctx;
  logic [63:0] rd_pc, rd_npc;
  logic [8:0]  rd_kind;

  always #2 clk = ~clk;

  trap_entry_unit u0 (
    .clk(clk), .rst(rst), .entry_go(entry_go), .trap_kind(trap_kind),
    .to_hyper(to_hyper), .to_red(to_red), .cur_tl(cur_tl), .cur_gl(cur_gl),
    .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
    .cur_hpstate(cur_hpstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .rd_level(rd_level), .done(done),
    .new_tl(new_tl), .new_gl(new_gl), .new_pstate(new_pstate),
    .new_hpstate(new_hpstate), .new_cwp(new_cwp), .rd_ctx(rd_ctx),
    .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_hpstate(rd_hpstate), .rd_kind(rd_kind)
  );

  int checks = 0, fails = 0;
  bit armed = 0, finished = 0;

  // reference model state
  longint unsigned m_done, m_tl, m_gl, m_ps, m_hp, m_cwp;
  longint unsigned s_ctx[MAX_TL+1], s_pc[MAX_TL+1], s_npc[MAX_TL+1], s_hp[MAX_TL+1], s_tt[MAX_TL+1];
  bit              s_ok[MAX_TL+1];
  longint unsigned e_ctx, e_pc, e_npc, e_hp, e_tt;
  bit              e_ok;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_done = 0; m_tl = 0; m_gl = 0; m_ps = 0; m_hp = 0; m_cwp = 0;
      e_ctx = 0; e_pc = 0; e_npc = 0; e_hp = 0; e_tt = 0; e_ok = 1;
      for (int i = 0; i <= MAX_TL; i++) s_ok[i] = 0;
    end else begin
      int lvl;
      // read port: old contents
      if (rd_level == 0 || rd_level > MAX_TL) begin
        e_ok = 1; e_ctx = 0; e_pc = 0; e_npc = 0; e_hp = 0; e_tt = 0;
      end else begin
        e_ok = s_ok[rd_level]; e_ctx = s_ctx[rd_level]; e_pc = s_pc[rd_level];
        e_npc = s_npc[rd_level]; e_hp = s_hp[rd_level]; e_tt = s_tt[rd_level];
      end
      m_done = entry_go;
      if (entry_go) begin
        bit priv;
        int g, cap, c;
        longint unsigned p, h;
        priv = !to_red && !to_hyper;
        lvl = (cur_tl + 1 > MAX_TL) ? MAX_TL : cur_tl + 1;
        g = cur_gl + 1; cap = priv ? MAX_PGL : MAX_GL;
        if (g > cap) g = cap;
        p = cur_pstate; p = p | 16; p = p & ~64'd8; p = p & ~64'd2;
        if (priv) p = p | 4; else p = p & ~64'd4;
        if (to_red) p = p & ~64'd512;
        h = cur_hpstate;
        if (to_red) begin h = h | 32 | 4; h = h & ~64'd1024; h = h & ~64'd1; end
        else if (to_hyper) begin h = h & ~64'd32; h = h | 4; end
        c = cur_cwp;
        if (trap_kind == 9'h024) c = c + 1;
        else if (trap_kind >= 9'h080 && trap_kind <= 9'h0BF) c = c + cur_cansave + 2;
        else if (trap_kind >= 9'h0C0 && trap_kind <= 9'h0FF) c = c - 1;
        c = ((c % NWIN) + NWIN) % NWIN;
        s_ctx[lvl] = (longint'(cur_gl) << 40) | (longint'(cur_ccr) << 32) |
                     (longint'(cur_asi) << 24) | (longint'(cur_pstate) << 8) | longint'(cur_cwp);
        s_pc[lvl] = cur_pc; s_npc[lvl] = cur_npc; s_hp[lvl] = cur_hpstate;
        s_tt[lvl] = trap_kind; s_ok[lvl] = 1;
        m_tl = lvl; m_gl = g; m_ps = p; m_hp = h; m_cwp = c;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk("R11 done", done, m_done);
      chk("R1 new_tl", new_tl, m_tl);
      chk("R4 new_gl", new_gl, m_gl);
      chk("R5,R6 new_pstate", new_pstate, m_ps);
      chk("R7,R8 new_hpstate", new_hpstate, m_hp);
      chk("R9,R10 new_cwp", new_cwp, m_cwp);
      if (e_ok) begin
        chk("R2 rd_ctx", rd_ctx, e_ctx);
        chk("R3 rd_pc", rd_pc, e_pc);
        chk("R3 rd_npc", rd_npc, e_npc);
        chk("R3 rd_hpstate", rd_hpstate, e_hp);
        chk("R3 rd_kind", rd_kind, e_tt);
      end
    end
  end

  task automatic entry(input logic [8:0] k, input bit hyp, input bit red,
                       input int tl, input int gl, input int cwp, input int cs);
    int lvl;
    @(negedge clk);
    entry_go = 1; trap_kind = k; to_hyper = hyp; to_red = red;
    cur_tl = 3'(tl); cur_gl = 2'(gl); cur_cwp = 3'(cwp); cur_cansave = 3'(cs);
    cur_ccr = 8'($urandom); cur_asi = 8'($urandom);
    cur_pstate = 13'($urandom); cur_hpstate = 11'($urandom);
    cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
    lvl = (tl + 1 > MAX_TL) ? MAX_TL : tl + 1;
    @(negedge clk);
    entry_go = 0; rd_level = 3'(lvl);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R9 clean-window type, privileged, R4 GL stays at privileged cap
    entry(9'h024, 0, 0, 0, 2, 3, 0);
    // R10 increment wraps 7 -> 0
    entry(9'h024, 1, 0, 1, 3, 7, 0);
    // R9 spill range with free-window count, R10 wrap 6+5+2
    entry(9'h085, 1, 0, 2, 1, 6, 5);
    entry(9'h0BF, 0, 0, 3, 0, 0, 0);
    // R10 fill below zero wraps to 7
    entry(9'h0C0, 0, 0, 4, 1, 0, 2);
    entry(9'h0FF, 1, 0, 5, 2, 4, 1);
    // R1 saturation at top level
    entry(9'h041, 0, 0, 6, 0, 5, 3);
    // R7 RED entry, RED overriding hyperprivileged
    entry(9'h005, 0, 1, 0, 3, 2, 1);
    entry(9'h0C5, 1, 1, 2, 2, 1, 1);
    // R4 privileged with GL above its cap drops to 2
    entry(9'h100, 0, 0, 3, 3, 2, 2);
    // boundary types just outside the ranges: no window move
    entry(9'h07F, 0, 0, 1, 0, 3, 4);
    entry(9'h023, 1, 0, 1, 0, 3, 4);
    // R2 out-of-range read levels
    @(negedge clk); rd_level = 3'd0;
    @(negedge clk); rd_level = 3'd7;
    @(negedge clk);
    // R3 earlier slots still readable
    for (int l = 1; l <= MAX_TL; l++) begin
      @(negedge clk); rd_level = 3'(l);
    end
    @(negedge clk);
    // R3 same-cycle read and write of one slot returns old contents
    @(negedge clk);
    rd_level = 3'd2; entry_go = 1; trap_kind = 9'h024; to_hyper = 0; to_red = 0;
    cur_tl = 3'd1; cur_pc = 64'h1234; cur_npc = 64'h1238;
    @(negedge clk); entry_go = 0;
    @(negedge clk);
    // mixed stimulus
    for (int n = 0; n < 300; n++) begin
      entry(9'($urandom), 1'($urandom), ($urandom % 4) == 0,
            $urandom % (MAX_TL + 1), $urandom % 4, $urandom % NWIN, $urandom % NWIN);
      if ((n % 7) == 0) begin
        @(negedge clk); rd_level = 3'($urandom);
        @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
    // R11 reset clears outputs
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule